// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for the two-wire management bus that connects a MAC to its PHYs. Software writes one 32-bit command word. The block sends 32 preamble ones on MDIO, then shifts the command word out most-significant bit first, one bit per MDC period. The same word format carries both classic (start code 01) and extended (start code 00) frames. An extended access is made of two frames that software issues one after the other: an address frame, then a read or write frame.

For read opcodes the master stops driving MDIO at the turnaround. It then clocks the PHY's 16 reply bits in on rising MDC edges and returns them in the low half of the command register. Each finished frame sets a sticky completion flag that software clears by writing a one to it. A clock-control register sets the MDC half-period and the hold time from the falling MDC edge to the next MDIO change.

Registers are selected by `regAddr`. Address 0 is the command/data word. Address 1 is clock control, with the divisor in bits [6:1] and the hold time in bits [10:8]. Address 2 holds events: bit 0 is completion and bit 1 is busy. Address 3 reads as zero. For a 250 MHz system clock the usual divisor is 63, the ceiling of 250/4.

Top module: `mdio_master`

## Requirements
- R1: After reset, MDC is low, MDIO is not driven, and addresses 0, 1 and 2 all read as zero.
- R2: A write to address 0 while idle starts a frame. The frame is 32 ones followed by the written word, bit 31 first. Each bit is presented on MDIO across one rising MDC edge. The word layout is [31:30] start, [29:28] opcode, [27:23] PHY address, [22:18] register or device address, [17:16] turnaround, [15:0] data.
- R3: If opcode bit 1 (word bit 29) is set, the frame is a read. The master drives only the first 46 bit times and releases MDIO for the remaining 18, starting with the two turnaround bits.
- R4: In a read, the last 16 bit times are sampled from `mdioIn` on rising MDC edges, first bit as the MSB. At completion they replace bits [15:0] of address 0, and bits [31:16] keep the written value.
- R5: A frame with opcode bit 1 clear (write or address) drives MDIO for all 64 bit times and leaves address 0 unchanged.
- R6: Completion sets bit 0 of address 2. The bit stays set until a write to address 2 with bit 0 set. A write with bit 0 clear leaves it set.
- R7: Bit 1 of address 2 reads 1 from the clock after the launching write until the frame ends. A frame lasts 128 × D system clocks, where D is the effective divisor.
- R8: A write to address 0 while busy is ignored. It starts no frame and does not change the register.
- R9: Each MDC half-period is D system clocks, where D is the divisor field (address 1 bits [6:1]). A field value of zero acts as 1.
- R10: MDIO changes H system clocks after MDC falls. H is the hold field (address 1 bits [10:8]), capped at D−1. MDIO never changes while MDC stays high.
- R11: Between frames MDC stays low and MDIO is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data (combinational on regAddr) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO output value |
| mdioOe | output | 1 | MDIO output enable (1 drives the line) |
| mdioIn | input | 1 | MDIO input from the pad |

## Verification
The assertions check on every cycle that MDC is low and MDIO is released when idle. They also check that MDIO holds steady while MDC is high, that the completion flag is set when busy drops, and that the command register does not move during a frame. Only the bench's scenarios can show the actual bit order of each frame kind, where the turnaround release falls, the captured read data, the exact frame length for several divisors (including zero), the measured hold delay with and without capping, and that a write during a frame is dropped.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CMD_W      = 32;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + CMD_W;
  localparam int TA_IDX     = FRAME_BITS - DATA_W - 2;
  localparam int DATA_IDX   = FRAME_BITS - DATA_W;
  localparam int RD_OP_BIT  = 29;
  localparam int ADDR_W     = 2;
  localparam logic [ADDR_W-1:0] ADDR_CMD = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CLK = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_EVT = 2'd2;

  typedef struct packed {
    logic load;
    logic advance;
    logic bodyBit;
    logic turnBit;
    logic sample;
    logic done;
  } mdioStrobes_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W  = 6,
  parameter int HOLD_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrite,
  input  logic              isRead,
  input  logic [DIV_W-1:0]  divVal,
  input  logic [HOLD_W-1:0] holdVal,
  output logic              busy,
  output logic              mdc,
  output mdioStrobes_t      st
);
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] PRE_IDX  = BIT_W'(PRE_BITS);
  localparam logic [BIT_W-1:0] TA_POS   = BIT_W'(TA_IDX);
  localparam logic [BIT_W-1:0] DATA_POS = BIT_W'(DATA_IDX);

  logic             busyQ, mdcQ;
  logic [DIV_W-1:0] phaseCnt, divEff, holdExt, holdCap;
  logic [BIT_W-1:0] bitIdx, tgtBit;
  logic             phaseEnd, riseNow, fallNow, lastBit;

  always_comb begin
    divEff   = (divVal == '0) ? DIV_W'(1) : divVal;
    holdExt  = DIV_W'(holdVal);
    holdCap  = (holdExt >= divEff) ? divEff - 1'b1 : holdExt;
    phaseEnd = (phaseCnt == divEff - 1'b1);
    riseNow  = busyQ && !mdcQ && phaseEnd;
    fallNow  = busyQ && mdcQ && phaseEnd;
    lastBit  = (bitIdx == LAST_IDX);
    tgtBit   = fallNow ? bitIdx + 1'b1 : bitIdx;

    st.load    = cmdWrite && !busyQ;
    st.advance = busyQ && ((fallNow && !lastBit && holdCap == '0) ||
                 (!mdcQ && holdCap != '0 && phaseCnt == holdCap - 1'b1 && bitIdx != '0));
    st.bodyBit = (tgtBit >= PRE_IDX);
    st.turnBit = (tgtBit >= TA_POS);
    st.sample  = riseNow && isRead && (bitIdx >= DATA_POS);
    st.done    = fallNow && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      mdcQ     <= 1'b0;
      phaseCnt <= '0;
      bitIdx   <= '0;
    end else if (st.load) begin
      busyQ    <= 1'b1;
      mdcQ     <= 1'b0;
      phaseCnt <= '0;
      bitIdx   <= '0;
    end else if (busyQ) begin
      if (phaseEnd) begin
        phaseCnt <= '0;
        mdcQ     <= ~mdcQ;
        if (fallNow) begin
          if (lastBit) begin
            busyQ  <= 1'b0;
            bitIdx <= '0;
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end
    end
  end

  assign busy = busyQ;
  assign mdc  = mdcQ;

  // R11
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> !mdcQ);

  // R7
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && !busyQ) |=> (busyQ && !mdcQ));
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 6,
  parameter int HOLD_W   = 3,
  parameter int DIV_LSB  = 1,
  parameter int HOLD_LSB = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CMD_W-1:0]  wrData,
  input  logic              busy,
  input  mdioStrobes_t      st,
  input  logic              mdioIn,
  output logic [CMD_W-1:0]  rdData,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic [DIV_W-1:0]  divVal,
  output logic [HOLD_W-1:0] holdVal,
  output logic              isRead
);
  logic [CMD_W-1:0]  cmdReg, shiftReg, clkWord;
  logic [DATA_W-1:0] capReg;
  logic [DIV_W-1:0]  clkDivQ;
  logic [HOLD_W-1:0] clkHoldQ;
  logic              evtQ, isReadQ, outQ, oeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg   <= '0;
      shiftReg <= '0;
      capReg   <= '0;
      isReadQ  <= 1'b0;
      outQ     <= 1'b1;
      oeQ      <= 1'b0;
    end else begin
      if (st.load) begin
        cmdReg   <= wrData;
        shiftReg <= wrData;
        isReadQ  <= wrData[RD_OP_BIT];
        outQ     <= 1'b1;
        oeQ      <= 1'b1;
      end else if (st.advance) begin
        if (st.bodyBit) begin
          outQ     <= shiftReg[CMD_W-1];
          shiftReg <= {shiftReg[CMD_W-2:0], 1'b0};
          oeQ      <= !(isReadQ && st.turnBit);
        end else begin
          outQ <= 1'b1;
        end
      end
      if (st.sample) capReg <= {capReg[DATA_W-2:0], mdioIn};
      if (st.done) begin
        oeQ <= 1'b0;
        if (isReadQ) cmdReg[DATA_W-1:0] <= capReg;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkDivQ  <= '0;
      clkHoldQ <= '0;
      evtQ     <= 1'b0;
    end else begin
      if (wrEn && regAddr == ADDR_CLK) begin
        clkDivQ  <= wrData[DIV_LSB +: DIV_W];
        clkHoldQ <= wrData[HOLD_LSB +: HOLD_W];
      end
      if (st.done) evtQ <= 1'b1;
      else if (wrEn && regAddr == ADDR_EVT && wrData[0]) evtQ <= 1'b0;
    end
  end

  always_comb begin
    clkWord = '0;
    clkWord[DIV_LSB +: DIV_W]   = clkDivQ;
    clkWord[HOLD_LSB +: HOLD_W] = clkHoldQ;
    case (regAddr)
      ADDR_CMD: rdData = cmdReg;
      ADDR_CLK: rdData = clkWord;
      ADDR_EVT: rdData = {{(CMD_W-2){1'b0}}, busy, evtQ};
      default:  rdData = '0;
    endcase
  end

  assign mdioOut = outQ;
  assign mdioOe  = oeQ;
  assign divVal  = clkDivQ;
  assign holdVal = clkHoldQ;
  assign isRead  = isReadQ;

  // R6
  done_sets_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> evtQ);

  // R11
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !oeQ);

  // R8
  cmd_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !st.done) |=> $stable(cmdReg));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 6,
  parameter int HOLD_W   = 3,
  parameter int DIV_LSB  = 1,
  parameter int HOLD_LSB = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CMD_W-1:0]  wrData,
  output logic [CMD_W-1:0]  rdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  mdioStrobes_t      st;
  logic              busy, isRead;
  logic [DIV_W-1:0]  divVal;
  logic [HOLD_W-1:0] holdVal;
  logic              cmdWrite;

  assign cmdWrite = wrEn && (regAddr == ADDR_CMD);

  mdio_ctrl #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .isRead(isRead),
    .divVal(divVal), .holdVal(holdVal), .busy(busy), .mdc(mdc), .st(st)
  );

  mdio_dp #(.DIV_W(DIV_W), .HOLD_W(HOLD_W), .DIV_LSB(DIV_LSB), .HOLD_LSB(HOLD_LSB)) uDp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .busy(busy), .st(st), .mdioIn(mdioIn), .rdData(rdData), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .divVal(divVal), .holdVal(holdVal), .isRead(isRead)
  );

  // R10
  steady_while_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> $stable(mdioOut));
endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {command word, PHY reply, divisor}
  localparam logic [53:0] VEC [NVEC] = '{
    {32'h618A0000, 16'hA5C3, 6'd2},
    {32'h5F828000, 16'h0000, 6'd3},
    {32'h00921234, 16'h0000, 6'd0},
    {32'h30920000, 16'h5A3C, 6'd1},
    {32'h110EBEEF, 16'h0000, 6'd2},
    {32'h60060000, 16'h0001, 6'd4}
  };

  logic        clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, mdioIn = 1'b1;
  logic [1:0]  regAddr = 2'd2;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        mdc, mdioOut, mdioOe;
  int total = 0, bad = 0;

  mdio_master u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0; regAddr = 2'd2;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1; d = rdData;
    regAddr = 2'd2;
  endtask

  task automatic runFrame(input logic [15:0] resp, input int intrudeAt, input logic [31:0] intrudeWord,
                          output logic [63:0] bits, output logic [63:0] oes, output int busyCnt);
    int  k = 0;
    int  cyc = 0;
    bit  running = 1'b1;
    logic prevMdc = 1'b0;
    logic busyNow;
    bits = '0; oes = '0; busyCnt = 0;
    while (running && cyc < 20000) begin
      #1;
      busyNow = (regAddr == 2'd2) ? rdData[1] : 1'b1;
      if (!busyNow) running = 1'b0;
      else begin
        busyCnt++;
        if (mdc && !prevMdc && k < 64) begin
          bits[63-k] = mdioOut; oes[63-k] = mdioOe; k++;
        end
        if (!mdc && prevMdc) mdioIn = (k >= 48 && k < 64) ? resp[63-k] : 1'b1;
        prevMdc = mdc;
      end
      if (cyc == intrudeAt) begin wrEn = 1'b1; regAddr = 2'd0; wrData = intrudeWord; end
      else begin wrEn = 1'b0; regAddr = 2'd2; end
      cyc++;
      if (running) @(negedge clk);
    end
    wrEn = 1'b0; regAddr = 2'd2;
  endtask

  task automatic holdTest(input int dv, input int hd, input int expD);
    int  sinceFall = 1000;
    int  measured = -1;
    logic prevMdc = 1'b0, prevOut = 1'b1;
    regWrite(2'd1, (32'(hd) << 8) | (32'(dv) << 1));
    regWrite(2'd0, 32'h5F825555);
    for (int c = 0; c < 20000; c++) begin
      #1;
      if (!mdc && prevMdc) sinceFall = 0; else sinceFall++;
      if (measured < 0 && mdioOut != prevOut) measured = sinceFall;
      prevMdc = mdc; prevOut = mdioOut;
      if (!rdData[1]) break;
      @(negedge clk);
    end
    // R10 delay from MDC fall to MDIO change
    chk(measured == expD, "R10", "hold delay", 64'(measured), 64'(expD));
    regWrite(2'd2, 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    logic [63:0] bits, oes, expBits, mask, expOes;
    int busyCnt, dEff;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #1;
    chk(mdc == 1'b0 && mdioOe == 1'b0, "R1", "pins after reset", {62'b0, mdc, mdioOe}, 64'h0);
    regRead(2'd0, rv); chk(rv == 32'h0, "R1", "cmd reg", 64'(rv), 64'h0);
    regRead(2'd1, rv); chk(rv == 32'h0, "R1", "clk reg", 64'(rv), 64'h0);
    regRead(2'd2, rv); chk(rv == 32'h0, "R1", "evt reg", 64'(rv), 64'h0);

    // table-driven frames: R2 R3 R4 R5 R7 R9
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] cmd; logic [15:0] resp; logic [5:0] dv; logic rd;
      {cmd, resp, dv} = VEC[i];
      rd = cmd[29];
      dEff = (dv == 0) ? 1 : int'(dv);
      regWrite(2'd1, 32'(dv) << 1);
      regRead(2'd1, rv);
      chk(rv == (32'(dv) << 1), "R9", "divisor readback", 64'(rv), 64'(32'(dv) << 1));
      regWrite(2'd0, cmd);
      runFrame(resp, -1, 32'h0, bits, oes, busyCnt);
      expBits = {32'hFFFFFFFF, cmd};
      mask    = rd ? 64'hFFFFFFFFFFFC0000 : 64'hFFFFFFFFFFFFFFFF;
      expOes  = mask;
      chk((bits & mask) == (expBits & mask), "R2", "frame bits", bits & mask, expBits & mask);
      chk(oes == expOes, rd ? "R3" : "R5", "drive pattern", oes, expOes);
      chk(busyCnt == 128 * dEff, "R7", "frame length (R9 divisor)", 64'(busyCnt), 64'(128 * dEff));
      regRead(2'd0, rv);
      chk(rv == (rd ? {cmd[31:16], resp} : cmd), rd ? "R4" : "R5", "cmd readback",
          64'(rv), 64'(rd ? {cmd[31:16], resp} : cmd));
      regRead(2'd2, rv);
      chk(rv == 32'h1, "R6", "event set", 64'(rv), 64'h1);
      regWrite(2'd2, 32'h1);
    end

    // R6 write of zero keeps the event, write of one clears it
    regWrite(2'd1, 32'd2 << 1);
    regWrite(2'd0, 32'h5F820001);
    runFrame(16'h0, -1, 32'h0, bits, oes, busyCnt);
    regWrite(2'd2, 32'h0);
    regRead(2'd2, rv); chk(rv == 32'h1, "R6", "after write 0", 64'(rv), 64'h1);
    regWrite(2'd2, 32'h1);
    regRead(2'd2, rv); chk(rv == 32'h0, "R6", "after write 1", 64'(rv), 64'h0);

    // R8 write while busy is dropped
    regWrite(2'd0, 32'h5F824321);
    runFrame(16'h0, 40, 32'h618AFFFF, bits, oes, busyCnt);
    chk(bits == {32'hFFFFFFFF, 32'h5F824321}, "R8", "frame unaffected", bits, {32'hFFFFFFFF, 32'h5F824321});
    chk(busyCnt == 256, "R8", "length unaffected", 64'(busyCnt), 64'd256);
    regRead(2'd0, rv); chk(rv == 32'h5F824321, "R8", "cmd reg unchanged", 64'(rv), 64'h5F824321);
    regWrite(2'd2, 32'h1);
    begin
      int toggles = 0; int drives = 0;
      for (int c = 0; c < 300; c++) begin
        @(negedge clk); #1;
        if (mdc) toggles++;
        if (mdioOe) drives++;
      end
      // R8 no second frame; R11 idle pins
      chk(toggles == 0, "R8", "no relaunch", 64'(toggles), 64'h0);
      chk(drives == 0, "R11", "idle release", 64'(drives), 64'h0);
    end

    // R10 hold delay, plain and capped
    holdTest(6, 3, 3);
    holdTest(6, 7, 5);
    holdTest(2, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule